// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block sits behind the command pins of a four-bank double-data-rate SDRAM device. On every rising clock edge it samples clock enable, chip select, the three strobe lines, the bank address and the multiplexed address bus, and turns them into exactly one decoded command. Clock enable is compared with its value from the previous edge. That comparison separates auto refresh from self-refresh entry, and it marks power-down entry and exit.

Next to the decode, the block tracks which banks hold an open row. It also keeps the mode register, with its burst length, burst type and CAS latency fields. Commands that cannot apply to the current bank state are flagged and leave that state untouched. Mode opcodes that the device does not support are flagged and not stored. Downstream array and data-path logic use the one-hot command strobe together with the latched bank, row, column and auto-precharge outputs.

Top module: `dram_cmd_decoder`

## Requirements
- R1: In reset, `cmd_onehot` shows no-operation (bit 0) and no bank is open. The mode register holds burst-length code 001, sequential type (0) and CAS-latency code 011. Both illegal flags are low.
- R2: When clock enable is high on this edge and the previous one, chip select high decodes as no-operation (bit 0) whatever the other pins carry. In that case bank and mode state stay unchanged.
- R3: With clock enable high on both edges and chip select low, {ras_n,cas_n,we_n} decodes as follows: 000 mode set (bit 1), 011 activate (bit 2), 101 read (bit 3), 100 write (bit 4), 010 precharge (bit 5), 110 burst stop (bit 6), 001 auto refresh (bit 7), 111 no-operation (bit 0).
- R4: Clock enable falling from high to low gives self-refresh entry (bit 8) when the refresh pattern (cs_n=0, ras_n=0, cas_n=0, we_n=1) is present, and power-down entry (bit 9) for any other pattern. Rising from low to high gives power-down exit (bit 10) for any pins. Low on both edges gives no-operation.
- R5: Activate to a closed bank opens it and latches `cmd_row` from all 11 address bits. Activate to an open bank raises `illegal_cmd` and changes no bank state.
- R6: Read or write latches `cmd_col` from address bits 7:0 and `cmd_autopre` from address bit 8. If the target bank is closed, `illegal_cmd` is raised. With auto precharge on an open bank, that bank closes.
- R7: Precharge with address bit 8 high closes every bank. With bit 8 low it closes only the bank on `ba`.
- R8: Mode set takes burst length from address bits 2:0, burst type from bit 3 and CAS latency from bits 6:4. Supported codes are length 001 (2) or 010 (4), and latency 011 (3). Any other code raises `illegal_mode` and the register keeps its old value.
- R9: All outputs are registered. The result of the pins sampled on one edge appears right after that edge, and `cmd_onehot` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Multiplexed row/column/opcode bus |
| cmd_onehot | output | 11 | One-hot decoded command |
| cmd_bank | output | 2 | Bank of last activate/read/write/precharge |
| cmd_row | output | 11 | Row of last activate |
| cmd_col | output | 8 | Column of last read/write |
| cmd_autopre | output | 1 | Address bit 8 of this read/write/precharge |
| illegal_cmd | output | 1 | Command conflicts with bank state |
| illegal_mode | output | 1 | Mode set with unsupported code |
| bank_open | output | 4 | One bit per bank, row open |
| mode_bl | output | 3 | Stored burst-length code |
| mode_bt | output | 1 | Stored burst type, 1 = interleaved |
| mode_cl | output | 3 | Stored CAS-latency code |

## Verification
The bench builds the block with its defaults: four banks, an 11-bit row and an 8-bit column, with auto precharge on bit 8. Two bank bits give enough banks to show that a per-bank precharge leaves the other banks open while a precharge with bit 8 high clears all of them. The 11-bit bus lets the all-ones row and a column with bit 8 set appear on the outputs. The vector walk steps clock enable through every pair of edge values, so each transition between power states is reached.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [3:0] {
    C_NOP = 4'd0, C_MRS = 4'd1, C_ACT = 4'd2, C_RD  = 4'd3,
    C_WR  = 4'd4, C_PRE = 4'd5, C_BST = 4'd6, C_REF = 4'd7,
    C_SRE = 4'd8, C_PDE = 4'd9, C_PDX = 4'd10
  } cmd_e;

  localparam int NUM_CMDS = 11;
  localparam int MODE_W   = 7;

  // Pin pattern to command; clock-enable history is checked first.
  function automatic cmd_e classify(input logic cke_prev, input logic cke_now,
                                    input logic cs_n, input logic ras_n,
                                    input logic cas_n, input logic we_n);
    cmd_e c;
    logic refresh_pat;
    refresh_pat = !cs_n && !ras_n && !cas_n && we_n;
    if (!cke_prev)      c = cke_now ? C_PDX : C_NOP;
    else if (!cke_now)  c = refresh_pat ? C_SRE : C_PDE;
    else if (cs_n)      c = C_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  c = C_MRS;
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b010:  c = C_PRE;
        3'b110:  c = C_BST;
        3'b001:  c = C_REF;
        default: c = C_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic burst_len_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010);
  endfunction

  function automatic logic cas_lat_ok(input logic [2:0] code);
    return code == 3'b011;
  endfunction

endpackage

// File: rtl/dcd_bank_tracker.sv
module dcd_bank_tracker
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 ap,
  output logic [NUM_BANKS-1:0] open_q,
  output logic                 conflict
);

  logic target_open;
  logic is_act, is_rw, is_pre;

  assign target_open = open_q[ba];
  assign is_act = (cmd == C_ACT);
  assign is_rw  = (cmd == C_RD) || (cmd == C_WR);
  assign is_pre = (cmd == C_PRE);
  assign conflict = (is_act && target_open) || (is_rw && !target_open);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
      end else if (is_act && sel && !open_q[i]) begin
        open_q[i] <= 1'b1;
      end else if (is_rw && sel && ap && open_q[i]) begin
        open_q[i] <= 1'b0;
      end else if (is_pre && (ap || sel)) begin
        open_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dcd_mode_reg.sv
module dcd_mode_reg
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] opcode,
  output logic [2:0]        bl,
  output logic              bt,
  output logic [2:0]        cl,
  output logic              bad
);

  assign bad = !burst_len_ok(opcode[2:0]) || !cas_lat_ok(opcode[6:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl <= 3'b001;
      bt <= 1'b0;
      cl <= 3'b011;
    end else if (wr_en && !bad) begin
      bl <= opcode[2:0];
      bt <= opcode[3];
      cl <= opcode[6:4];
    end
  end

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ROW_W-1:0]     addr,
  output logic [NUM_CMDS-1:0]  cmd_onehot,
  output logic [BA_W-1:0]      cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 cmd_autopre,
  output logic                 illegal_cmd,
  output logic                 illegal_mode,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [2:0]           mode_bl,
  output logic                 mode_bt,
  output logic [2:0]           mode_cl
);

  logic cke_q;
  cmd_e cmd_now;
  logic is_mrs, is_act, is_rw, is_pre;
  logic bank_conflict, mode_bad;

  assign cmd_now = classify(cke_q, cke, cs_n, ras_n, cas_n, we_n);
  assign is_mrs  = (cmd_now == C_MRS);
  assign is_act  = (cmd_now == C_ACT);
  assign is_rw   = (cmd_now == C_RD) || (cmd_now == C_WR);
  assign is_pre  = (cmd_now == C_PRE);

  dcd_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_now),
    .ba       (ba),
    .ap       (addr[AP_BIT]),
    .open_q   (bank_open),
    .conflict (bank_conflict)
  );

  dcd_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (is_mrs),
    .opcode (addr[MODE_W-1:0]),
    .bl     (mode_bl),
    .bt     (mode_bt),
    .cl     (mode_cl),
    .bad    (mode_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q        <= 1'b1;
      cmd_onehot   <= NUM_CMDS'(1);
      cmd_bank     <= '0;
      cmd_row      <= '0;
      cmd_col      <= '0;
      cmd_autopre  <= 1'b0;
      illegal_cmd  <= 1'b0;
      illegal_mode <= 1'b0;
    end else begin
      cke_q        <= cke;
      cmd_onehot   <= NUM_CMDS'(1) << cmd_now;
      cmd_autopre  <= (is_rw || is_pre) && addr[AP_BIT];
      illegal_cmd  <= bank_conflict;
      illegal_mode <= is_mrs && mode_bad;
      if (is_act || is_rw || is_pre) cmd_bank <= ba;
      if (is_act) cmd_row <= addr;
      if (is_rw)  cmd_col <= addr[COL_W-1:0];
    end
  end

endmodule

// File: rtl/dram_cmd_decoder_chk.sv
module dram_cmd_decoder_chk
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cke_q,
  input logic                 cs_n,
  input logic [NUM_CMDS-1:0]  cmd_onehot,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 cmd_autopre,
  input logic                 illegal_cmd,
  input logic                 illegal_mode,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [2:0]           mode_bl,
  input logic                 mode_bt,
  input logic [2:0]           mode_cl
);

  p_onehot_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_onehot) == 1);

  p_deselect_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && cke_q) |=> cmd_onehot[C_NOP]);

  p_pd_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && cke) |=> cmd_onehot[C_PDX]);

  p_act_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_onehot[C_ACT] && !illegal_cmd) |-> bank_open[cmd_bank]);

  p_illegal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> $stable(bank_open));

  p_autopre_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_onehot[C_RD] || cmd_onehot[C_WR]) && cmd_autopre && !illegal_cmd)
      |-> !bank_open[cmd_bank]);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_onehot[C_MRS] || illegal_mode) |-> $stable({mode_bl, mode_bt, mode_cl}));

  p_cl_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cl == 3'b011);

endmodule

bind dram_cmd_decoder dram_cmd_decoder_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .cke_q        (cke_q),
  .cs_n         (cs_n),
  .cmd_onehot   (cmd_onehot),
  .cmd_bank     (cmd_bank),
  .cmd_autopre  (cmd_autopre),
  .illegal_cmd  (illegal_cmd),
  .illegal_mode (illegal_mode),
  .bank_open    (bank_open),
  .mode_bl      (mode_bl),
  .mode_bt      (mode_bt),
  .mode_cl      (mode_cl)
);

// File: tb/dram_cmd_decoder_tb_top.sv
module dram_cmd_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [10:0] cmd_onehot;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0]  cmd_col;
  logic        cmd_autopre, illegal_cmd, illegal_mode, mode_bt;
  logic [3:0]  bank_open;
  logic [2:0]  mode_bl, mode_cl;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dram_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .illegal_cmd(illegal_cmd),
    .illegal_mode(illegal_mode), .bank_open(bank_open), .mode_bl(mode_bl),
    .mode_bt(mode_bt), .mode_cl(mode_cl)
  );

  // {cke, cs/ras/cas/we, ba, addr, expected command bit, expected illegal, expected open}
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 4'b0111, 2'd0, 11'h000, 4'd0,  1'b0, 4'b0000}, // R3 nop
    {1'b1, 4'b0011, 2'd1, 11'h155, 4'd2,  1'b0, 4'b0010}, // R5 act bank1
    {1'b1, 4'b0011, 2'd1, 11'h000, 4'd2,  1'b1, 4'b0010}, // R5 act open bank
    {1'b1, 4'b0101, 2'd1, 11'h0A5, 4'd3,  1'b0, 4'b0010}, // R6 read
    {1'b1, 4'b0100, 2'd2, 11'h000, 4'd4,  1'b1, 4'b0010}, // R6 write closed
    {1'b1, 4'b1011, 2'd0, 11'h000, 4'd0,  1'b0, 4'b0010}, // R2 deselect
    {1'b1, 4'b0011, 2'd3, 11'h000, 4'd2,  1'b0, 4'b1010}, // R5 act bank3
    {1'b1, 4'b0110, 2'd0, 11'h000, 4'd6,  1'b0, 4'b1010}, // R3 burst stop
    {1'b1, 4'b0100, 2'd3, 11'h100, 4'd4,  1'b0, 4'b0010}, // R6 write autopre
    {1'b1, 4'b0011, 2'd0, 11'h000, 4'd2,  1'b0, 4'b0011}, // R5 act bank0
    {1'b1, 4'b0010, 2'd0, 11'h000, 4'd5,  1'b0, 4'b0010}, // R7 precharge one
    {1'b1, 4'b0011, 2'd2, 11'h000, 4'd2,  1'b0, 4'b0110}, // R5 act bank2
    {1'b1, 4'b0010, 2'd0, 11'h100, 4'd5,  1'b0, 4'b0000}, // R7 precharge all
    {1'b1, 4'b0001, 2'd0, 11'h000, 4'd7,  1'b0, 4'b0000}, // R3 refresh
    {1'b0, 4'b0001, 2'd0, 11'h000, 4'd8,  1'b0, 4'b0000}, // R4 self-refresh entry
    {1'b0, 4'b0111, 2'd0, 11'h000, 4'd0,  1'b0, 4'b0000}, // R4 low-low
    {1'b1, 4'b0111, 2'd0, 11'h000, 4'd10, 1'b0, 4'b0000}, // R4 exit
    {1'b0, 4'b0111, 2'd0, 11'h000, 4'd9,  1'b0, 4'b0000}, // R4 power-down entry
    {1'b1, 4'b1111, 2'd0, 11'h000, 4'd10, 1'b0, 4'b0000}, // R4 exit with cs high
    {1'b1, 4'b0000, 2'd0, 11'h032, 4'd1,  1'b0, 4'b0000}, // R8 mode set
    {1'b1, 4'b0101, 2'd0, 11'h100, 4'd3,  1'b1, 4'b0000}  // R6 read closed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] c, input logic [1:0] b,
                       input logic [10:0] a);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 cmd", 32'(cmd_onehot), 32'h1);
    check("R1 open", 32'(bank_open), 32'h0);
    check("R1 mode", 32'({mode_bl, mode_bt, mode_cl}), 32'({3'b001, 1'b0, 3'b011}));
    check("R1 flags", 32'({illegal_cmd, illegal_mode}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26], VEC[i][25:22], VEC[i][21:20], VEC[i][19:9]);
      check("R3/R9 cmd", 32'(cmd_onehot), 32'(11'(1) << VEC[i][8:5]));
      check("R5/R6 illegal", 32'(illegal_cmd), 32'(VEC[i][4]));
      check("R5/R7 open", 32'(bank_open), 32'(VEC[i][3:0]));
    end
    check("R8 mode stored", 32'({mode_bl, mode_bt, mode_cl}), 32'({3'b010, 1'b0, 3'b011}));

    // R8: unsupported latency code is flagged and not stored
    drive(1'b1, 4'b0000, 2'd0, 11'h00A);
    check("R8 bad flag", 32'(illegal_mode), 32'h1);
    check("R8 held", 32'({mode_bl, mode_bt, mode_cl}), 32'({3'b010, 1'b0, 3'b011}));
    // R8: burst length 8 is flagged
    drive(1'b1, 4'b0000, 2'd0, 11'h01B);
    check("R8 bad bl", 32'(illegal_mode), 32'h1);
    drive(1'b1, 4'b0000, 2'd0, 11'h039);
    check("R8 interleaved", 32'({illegal_mode, mode_bl, mode_bt, mode_cl}),
          32'({1'b0, 3'b001, 1'b1, 3'b011}));

    // R2: deselect with a mode-set pattern leaves the mode register alone
    drive(1'b1, 4'b1000, 2'd0, 11'h032);
    check("R2 mode", 32'({mode_bl, mode_bt, cmd_onehot}), 32'({3'b001, 1'b1, 11'h001}));

    // R5: row latch with all-ones address
    drive(1'b1, 4'b0011, 2'd0, 11'h7FF);
    check("R5 row", 32'({cmd_bank, cmd_row}), 32'({2'd0, 11'h7FF}));
    // R6: column and auto-precharge
    drive(1'b1, 4'b0101, 2'd0, 11'h1AB);
    check("R6 col", 32'({cmd_col, cmd_autopre}), 32'({8'hAB, 1'b1}));
    check("R6 closed", 32'(bank_open), 32'h0);

    // R1: reset in mid-run clears bank state
    drive(1'b1, 4'b0011, 2'd3, 11'h000);
    check("R5 reopen", 32'(bank_open), 32'h8);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset", 32'({bank_open, cmd_onehot}), 32'({4'h0, 11'h001}));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule